// File: doc/BRIEF.md
# Asynchronous Bus Register Slave

This block is a device-register slave for an interlocked, clockless master/slave bus with an 18-bit byte address and a 16-bit data path. It owns a small bank of word registers placed at a base address inside the 8 KB device page at the top of the address space. The master places an address, a two-bit cycle code and, for writes, data on the bus, then asserts master-sync. The slave answers with slave-sync once it has taken the write data or presented the read data. It holds slave-sync until master-sync goes away.

All bus lines are active low. An internal clock samples them, and master-sync passes through a two-stage synchronizer before any other line is sampled. The block serves four cycle kinds: plain read, read with pause, full-word write and single-byte write. A read with pause is the first half of a read-modify-write. It marks the location as pending until a word or byte write to that same register ends the sequence, or until bus init clears the mark.

Top module: `async_bus_regslave`

## Requirements
- R1: After reset, slave-sync is high, the data drive enable is 0, the pending-pause flag is 0, and every register reads back 0.
- R2: The slave answers only addresses A with BASE <= A < BASE + 2*NREGS, where BASE lies in the top 8 KB page. For any other address it never asserts slave-sync and changes no register.
- R3: With cycle code 00 (the value of the active-low lines after inversion, line 1 as the MSB), the slave returns the register at word index (A-BASE)>>1. The data lines carry the inverted value, and the drive enable is high at least one clock before slave-sync falls.
- R4: Cycle code 10 writes the whole 16-bit word taken from the inverted data lines.
- R5: Cycle code 11 writes one byte. Address bit 0 = 0 updates bits 7:0, address bit 0 = 1 updates bits 15:8, and the other byte is kept.
- R6: Cycle code 01 returns the register like a read and sets the pending-pause flag for that register.
- R7: A word or byte write to the paused register clears the pending-pause flag. A write to any other register leaves the flag set.
- R8: Bus init low clears the pending-pause flag and drops an acknowledge in progress. It leaves register contents unchanged.
- R9: Once asserted, slave-sync and read data stay driven while master-sync stays asserted. After master-sync is released, slave-sync returns high and the drive enable returns to 0.
- R10: Slave-sync falls no earlier than the third clock edge after master-sync is asserted, so the two synchronizer stages always sit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_init_n | input | 1 | Bus initialize, active low |
| addr_n | input | 18 | Address lines, active low |
| ctl_n | input | 2 | Cycle-code lines, active low |
| data_in_n | input | 16 | Data lines as received, active low |
| data_out_n | output | 16 | Data lines as driven, active low, all ones when not driving |
| data_oe | output | 1 | Data driver enable |
| msync_n | input | 1 | Master-sync, active low |
| ssync_n | output | 1 | Slave-sync, active low |
| locked | output | 1 | Pending read-modify-write flag |

## Verification
Word writes of distinct patterns to every register, each followed by a read-back of the whole bank, show whether index decode mixes up registers. A sweep of byte writes over both lanes of every register shows whether lanes are steered wrongly or the other byte is lost. Addresses just below the window, just above it, and equal to the base except for one high bit show whether the range or the page is decoded wrongly. Pause sequences that end with a write to the paused register, a write to another register, or an init show how the flag is set and cleared.

// File: rtl/async_bus_regslave.sv
module async_bus_regslave #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NREGS  = 4,
  parameter logic [ADDR_W-1:0] BASE = 18'h3FF40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init_n,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [1:0]        ctl_n,
  input  logic [DATA_W-1:0] data_in_n,
  output logic [DATA_W-1:0] data_out_n,
  output logic              data_oe,
  input  logic              msync_n,
  output logic              ssync_n,
  output logic              locked
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int SPAN  = 2 * NREGS;
  localparam int HALF  = DATA_W / 2;
  localparam logic [1:0] C_RD = 2'b00, C_RDP = 2'b01, C_WW = 2'b10, C_WB = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_ACK} st_t;

  st_t               st;
  logic              ms1, ms2;
  logic [1:0]        cyc;
  logic [DATA_W-1:0] rdata;
  logic [IDX_W-1:0]  lock_idx;
  logic [DATA_W-1:0] regs [NREGS];

  wire [ADDR_W-1:0] addr  = ~addr_n;
  wire [1:0]        ctl   = ~ctl_n;
  wire [DATA_W-1:0] wdata = ~data_in_n;
  wire [ADDR_W-1:0] off   = addr - BASE;
  wire              hit   = (addr >= BASE) && (off < ADDR_W'(SPAN));
  wire [IDX_W-1:0]  idx   = off[IDX_W:1];
  wire              is_rd = (cyc == C_RD) || (cyc == C_RDP);

  assign data_oe    = (st != S_IDLE) && is_rd;
  assign data_out_n = data_oe ? ~rdata : '1;
  assign ssync_n    = (st != S_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms1 <= 1'b0;
      ms2 <= 1'b0;
      st <= S_IDLE;
      cyc <= C_WW;
      rdata <= '0;
      locked <= 1'b0;
      lock_idx <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      ms1 <= ~msync_n;
      ms2 <= ms1;
      if (!bus_init_n) begin
        st <= S_IDLE;
        locked <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (ms2 && hit) begin
            st <= S_DRIVE;
            cyc <= ctl;
            rdata <= regs[idx];
            case (ctl)
              C_RDP: begin
                locked <= 1'b1;
                lock_idx <= idx;
              end
              C_WW: begin
                regs[idx] <= wdata;
                if (locked && lock_idx == idx) locked <= 1'b0;
              end
              C_WB: begin
                if (addr[0]) regs[idx][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
                else         regs[idx][HALF-1:0]      <= wdata[HALF-1:0];
                if (locked && lock_idx == idx) locked <= 1'b0;
              end
              default: ;
            endcase
          end
          S_DRIVE: st <= S_ACK;
          S_ACK:   if (!ms2) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_data_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssync_n) && is_rd |-> $past(data_oe));
  a_r9_hold_while_msync: assert property (@(posedge clk) disable iff (!rst_n)
    !ssync_n && ms1 && ms2 && bus_init_n |=> !ssync_n && $stable(data_out_n));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    ssync_n |-> !data_oe || st == S_DRIVE);
  a_r6_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> cyc == C_RDP);
  a_r8_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_init_n |=> !locked && ssync_n);
  a_r10_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssync_n) |-> $past(ms2, 2) && $past(ms1, 3));
endmodule

// File: tb/async_bus_regslave_test.sv
`timescale 1ns/1ps
module async_bus_regslave_test;
  localparam logic [17:0] BASE = 18'h3FF40;
  localparam int NR = 4;

  logic clk = 0, rst_n = 0, bus_init_n = 1, msync_n = 1;
  logic [17:0] addr_n = '1;
  logic [1:0]  ctl_n = '1;
  logic [15:0] data_in_n = '1;
  wire  [15:0] data_out_n;
  wire data_oe, ssync_n, locked;

  int checks = 0, errors = 0;
  logic [15:0] model [NR];
  logic got_ack;
  logic [15:0] got_data;
  int ack_wait;
  logic oe_before;

  always #2.5 clk = ~clk;

  async_bus_regslave uut (
    .clk(clk), .rst_n(rst_n), .bus_init_n(bus_init_n), .addr_n(addr_n),
    .ctl_n(ctl_n), .data_in_n(data_in_n), .data_out_n(data_out_n),
    .data_oe(data_oe), .msync_n(msync_n), .ssync_n(ssync_n), .locked(locked));

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d);
    @(negedge clk);
    addr_n = ~a; ctl_n = ~c; data_in_n = ~d;
    @(negedge clk);
    msync_n = 0;
    got_ack = 0; ack_wait = 0; oe_before = 0; got_data = '0;
    for (int k = 0; k < 16 && !got_ack; k++) begin
      @(negedge clk);
      ack_wait++;
      if (!ssync_n) begin
        got_ack = 1;
        got_data = ~data_out_n;
      end else oe_before = data_oe;
    end
    if (got_ack) begin
      repeat (2) @(negedge clk);
      check(!ssync_n && (~data_out_n == got_data), "R9 hold", {15'd0, ssync_n, ~data_out_n}, {16'd0, got_data});
    end
    msync_n = 1;
    for (int k = 0; k < 16 && !ssync_n; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    if (got_ack) check(ssync_n && !data_oe, "R9 release", {ssync_n, data_oe}, 2'b10);
    addr_n = '1; ctl_n = '1; data_in_n = '1;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++) begin
      cycle(BASE + 18'(2*i), 2'b00, 16'h0);
      check(got_ack && got_data == model[i], tag, got_data, model[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ssync_n && !data_oe && !locked, "R1 reset outputs", {ssync_n, data_oe, locked}, 3'b100);
    read_all("R1 reset value");

    // R3 R4 R10: word writes with distinct patterns, read-back of whole bank
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < NR; i++) begin
        model[i] = 16'((i + 1) * 16'h1357 ^ (p * 16'h5A5A));
        cycle(BASE + 18'(2*i), 2'b10, model[i]);
        check(got_ack, "R4 write ack", got_ack, 1);
      end
      read_all("R4 word readback");
    end
    cycle(BASE + 18'd2, 2'b00, 16'h0);
    check(oe_before, "R3 data before ack", oe_before, 1);
    check(ack_wait >= 3, "R10 sync delay", ack_wait, 3);

    // R5 byte lane sweep
    for (int i = 0; i < NR; i++)
      for (int b = 0; b < 2; b++) begin
        logic [15:0] v;
        v = 16'(16'hC3A0 + i * 16'h0111 + b * 16'h1001);
        cycle(BASE + 18'(2*i + b), 2'b11, v);
        if (b == 1) model[i][15:8] = v[15:8]; else model[i][7:0] = v[7:0];
        cycle(BASE + 18'(2*i), 2'b00, 16'h0);
        check(got_data == model[i], "R5 byte lane", got_data, model[i]);
      end

    // R2 outside addresses
    begin
      logic [17:0] outs [3];
      outs[0] = BASE - 18'd2; outs[1] = BASE + 18'(2*NR); outs[2] = BASE ^ 18'h20000;
      for (int j = 0; j < 3; j++) begin
        cycle(outs[j], 2'b10, 16'hDEAD);
        check(!got_ack, "R2 no ack outside", got_ack, 0);
      end
      read_all("R2 bank untouched");
    end

    // R6 R7 pause then write to same register
    cycle(BASE + 18'd4, 2'b01, 16'h0);
    check(got_data == model[2] && locked, "R6 pause read", {locked, got_data}, {1'b1, model[2]});
    cycle(BASE + 18'd6, 2'b10, 16'h7777); model[3] = 16'h7777;
    check(locked, "R7 other write keeps lock", locked, 1);
    cycle(BASE + 18'd4, 2'b10, 16'h1234); model[2] = 16'h1234;
    check(!locked, "R7 word write clears", locked, 0);
    cycle(BASE + 18'd0, 2'b01, 16'h0);
    cycle(BASE + 18'd1, 2'b11, 16'hAB00); model[0][15:8] = 8'hAB;
    check(!locked, "R7 byte write clears", locked, 0);
    read_all("R7 bank after rmw");

    // R8 init clears lock, keeps registers
    cycle(BASE + 18'd2, 2'b01, 16'h0);
    check(locked, "R8 lock set before init", locked, 1);
    @(negedge clk); bus_init_n = 0;
    @(negedge clk); @(negedge clk); bus_init_n = 1;
    check(!locked, "R8 init clears lock", locked, 0);
    read_all("R8 registers kept");

    // R8 init drops an acknowledge in progress
    @(negedge clk);
    addr_n = ~BASE; ctl_n = ~2'b00;
    @(negedge clk); msync_n = 0;
    for (int k = 0; k < 16 && ssync_n; k++) @(negedge clk);
    check(!ssync_n, "R8 ack reached", ssync_n, 0);
    bus_init_n = 0;
    @(negedge clk);
    msync_n = 1;
    @(negedge clk);
    check(ssync_n, "R8 init drops ack", ssync_n, 1);
    repeat (3) @(negedge clk);
    bus_init_n = 1; addr_n = '1; ctl_n = '1;
    repeat (3) @(negedge clk);
    check(ssync_n && !data_oe, "R8 idle after init", {ssync_n, data_oe}, 2'b10);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule